// File: doc/BRIEF.md
# User-Mode Trap Control Registers

This block keeps the small set of control and status registers a core needs to handle traps in user mode without calling a more privileged layer. Instructions reach the registers through a single-cycle CSR port addressed by a 12-bit number. Reads return the current contents in the same cycle. Writes take effect at the next clock edge. The port never stalls, so it has no back-pressure.

When the pipeline takes a trap, it pulses `trap_valid` together with the faulting PC, the cause code and the offending address or instruction word. The block latches these values and pushes a one-level interrupt-enable stack. When the handler executes its return instruction, the pipeline pulses `uret_valid`. The block then pops the stack and clears the registers that are only meaningful inside a handler.

The block also drives three outputs to the pipeline. `trap_vector` is the handler entry point, `return_pc` is the address to resume at, and `irq_taken` reports that an enabled interrupt is pending and interrupts are globally enabled.

Top module: `utrap_csr_unit`

## Requirements
- R1: Each implemented register accepts a CSR write and returns the stored value on a read from the next cycle onward. The implemented registers are status 0x000, enable 0x004, vector 0x005, scratch 0x040, exception PC 0x041, cause 0x042, trap value 0x043 and pending 0x044. The enable, vector, scratch, cause and trap-value registers keep all 32 bits.
- R2: In status, bit 0 is the global enable (GIE) and bit 4 is the saved enable (SIE). All other status bits read as zero whatever is written.
- R3: On trap entry, SIE takes the old GIE and GIE becomes 0.
- R4: On return, GIE takes the old SIE and SIE becomes 1.
- R5: On trap entry, the exception PC takes `trap_pc` with bit 0 cleared, the cause takes `trap_cause` and the trap value takes `trap_tval`.
- R6: On return, the exception PC, cause and trap value all become zero. Before the return edge, `return_pc` shows the stored exception PC.
- R7: `irq_taken` is 1 exactly when GIE is 1 and the enable and pending registers share a set bit. While GIE is 0, `irq_taken` stays 0 whatever the other two registers hold.
- R8: Pending bit 0 is a software-writable flag. Pending bits 31:1 read the live `irq_lines` inputs, and writes to those bits are ignored.
- R9: A trap entry, or a return, in the same cycle as a CSR write makes the write have no effect on any register. A trap entry in the same cycle as a return behaves as a trap entry alone.
- R10: An access to any other address reads zero and raises `csr_illegal` in that cycle. Such a write changes no register.
- R11: After reset, every register reads zero except the vector register, which reads the `TVEC_RESET` parameter (default 0x103). `trap_vector` is the vector register with bits 1:0 cleared.
- R12: A write to the exception PC stores bit 0 as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_valid | input | 1 | CSR access this cycle |
| csr_write | input | 1 | Access is a write (else read) |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational |
| csr_illegal | output | 1 | Access hit no implemented register |
| trap_valid | input | 1 | Trap entry this cycle |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_cause | input | 32 | Cause code |
| trap_tval | input | 32 | Bad address or instruction |
| uret_valid | input | 1 | Trap return this cycle |
| irq_lines | input | 31 | External pending sources for pending bits 31:1 |
| trap_vector | output | 32 | Handler entry address |
| return_pc | output | 32 | Resume address |
| irq_taken | output | 1 | Enabled interrupt pending and GIE set |

## Verification
Assertions check, on every cycle, the enable stack after each trap entry and return, the capture and clearing of the handler registers, that an unimplemented address always reads zero, and that a write colliding with a trap is dropped. Only the bench scenarios can show the address map and field masks, that the live pending bits cannot be written, the gating of `irq_taken` under each combination of enable and pending, and the reset values that later writes overwrite.

// File: rtl/utrap_pkg.sv
package utrap_pkg;
  localparam int unsigned CSR_AW = 12;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_IE,
    SEL_TVEC,
    SEL_SCRATCH,
    SEL_EPC,
    SEL_CAUSE,
    SEL_TVAL,
    SEL_IP
  } csr_sel_e;

  localparam logic [CSR_AW-1:0] A_STATUS  = 12'h000;
  localparam logic [CSR_AW-1:0] A_IE      = 12'h004;
  localparam logic [CSR_AW-1:0] A_TVEC    = 12'h005;
  localparam logic [CSR_AW-1:0] A_SCRATCH = 12'h040;
  localparam logic [CSR_AW-1:0] A_EPC     = 12'h041;
  localparam logic [CSR_AW-1:0] A_CAUSE   = 12'h042;
  localparam logic [CSR_AW-1:0] A_TVAL    = 12'h043;
  localparam logic [CSR_AW-1:0] A_IP      = 12'h044;

  // status field positions
  localparam int unsigned ST_GIE = 0;
  localparam int unsigned ST_SIE = 4;
endpackage

// File: rtl/utrap_csr_decode.sv
module utrap_csr_decode
  import utrap_pkg::*;
(
  input  logic [CSR_AW-1:0] addr_i,
  output csr_sel_e          sel_o,
  output logic              hit_o
);
  always_comb begin
    case (addr_i)
      A_STATUS:  sel_o = SEL_STATUS;
      A_IE:      sel_o = SEL_IE;
      A_TVEC:    sel_o = SEL_TVEC;
      A_SCRATCH: sel_o = SEL_SCRATCH;
      A_EPC:     sel_o = SEL_EPC;
      A_CAUSE:   sel_o = SEL_CAUSE;
      A_TVAL:    sel_o = SEL_TVAL;
      A_IP:      sel_o = SEL_IP;
      default:   sel_o = SEL_NONE;
    endcase
    hit_o = (sel_o != SEL_NONE);
  end
endmodule

// File: rtl/utrap_status_stack.sv
module utrap_status_stack
  import utrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic            uret_i,
  input  logic            wr_i,
  input  logic            wr_gie_i,
  input  logic            wr_sie_i,
  output logic            gie_o,
  output logic            sie_o,
  output logic [XLEN-1:0] status_o
);
  logic gie_q, sie_q;

  // trap entry outranks return, return outranks a software write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      sie_q <= 1'b0;
    end else if (trap_i) begin
      sie_q <= gie_q;
      gie_q <= 1'b0;
    end else if (uret_i) begin
      gie_q <= sie_q;
      sie_q <= 1'b1;
    end else if (wr_i) begin
      gie_q <= wr_gie_i;
      sie_q <= wr_sie_i;
    end
  end

  always_comb begin
    status_o         = '0;
    status_o[ST_GIE] = gie_q;
    status_o[ST_SIE] = sie_q;
  end

  assign gie_o = gie_q;
  assign sie_o = sie_q;

  p_trap_pushes_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (!gie_q && (sie_q == $past(gie_q))));

  p_uret_pops_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uret_i && !trap_i) |=> (sie_q && (gie_q == $past(sie_q))));
endmodule

// File: rtl/utrap_handler_regs.sv
module utrap_handler_regs #(
  parameter int unsigned    XLEN       = 32,
  parameter logic [XLEN-1:0] TVEC_RESET = 32'h0000_0103
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_i,
  input  logic            uret_i,
  input  logic [XLEN-1:1] trap_pc_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_tval_i,
  input  logic            wr_epc_i,
  input  logic            wr_cause_i,
  input  logic            wr_tval_i,
  input  logic            wr_scratch_i,
  input  logic            wr_tvec_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] tval_o,
  output logic [XLEN-1:0] scratch_o,
  output logic [XLEN-1:0] tvec_o
);
  localparam int unsigned EPC_HI = XLEN - 1;

  logic [EPC_HI:1]  epc_hi_q;
  logic [XLEN-1:0]  cause_q, tval_q, scratch_q, tvec_q;

  // handler-only registers: trap captures, return clears
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_hi_q <= '0;
      cause_q  <= '0;
      tval_q   <= '0;
    end else if (trap_i) begin
      epc_hi_q <= trap_pc_i;
      cause_q  <= trap_cause_i;
      tval_q   <= trap_tval_i;
    end else if (uret_i) begin
      epc_hi_q <= '0;
      cause_q  <= '0;
      tval_q   <= '0;
    end else begin
      if (wr_epc_i)   epc_hi_q <= wdata_i[EPC_HI:1];
      if (wr_cause_i) cause_q  <= wdata_i;
      if (wr_tval_i)  tval_q   <= wdata_i;
    end
  end

  // persistent registers: software only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      tvec_q    <= TVEC_RESET;
    end else begin
      if (wr_scratch_i) scratch_q <= wdata_i;
      if (wr_tvec_i)    tvec_q    <= wdata_i;
    end
  end

  assign epc_o     = {epc_hi_q, 1'b0};
  assign cause_o   = cause_q;
  assign tval_o    = tval_q;
  assign scratch_o = scratch_q;
  assign tvec_o    = tvec_q;

  p_trap_captures_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> ((epc_o == {$past(trap_pc_i), 1'b0}) && (cause_o == $past(trap_cause_i))
                && (tval_o == $past(trap_tval_i))));

  p_uret_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uret_i && !trap_i) |=> ((epc_o == '0) && (cause_o == '0) && (tval_o == '0)));
endmodule

// File: rtl/utrap_irq_gate.sv
module utrap_irq_gate #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gie_i,
  input  logic            wr_ie_i,
  input  logic            wr_ip_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [XLEN-1:1] lines_i,
  output logic [XLEN-1:0] ie_o,
  output logic [XLEN-1:0] ip_o,
  output logic            taken_o
);
  logic [XLEN-1:0] ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ie_q <= '0;
    else if (wr_ie_i) ie_q <= wdata_i;
  end

  // bit 0 is a software flag, the rest follow their external source
  for (genvar gi = 0; gi < XLEN; gi++) begin : g_pend
    if (gi == 0) begin : g_soft
      logic soft_q;
      always_ff @(posedge clk) begin
        if (!rst_n)       soft_q <= 1'b0;
        else if (wr_ip_i) soft_q <= wdata_i[0];
      end
      assign ip_o[gi] = soft_q;
    end else begin : g_line
      assign ip_o[gi] = lines_i[gi];
    end
  end

  assign ie_o    = ie_q;
  assign taken_o = gie_i & (|(ie_q & ip_o));
endmodule

// File: rtl/utrap_csr_unit.sv
module utrap_csr_unit
  import utrap_pkg::*;
#(
  parameter int unsigned    XLEN       = 32,
  parameter logic [XLEN-1:0] TVEC_RESET = 32'h0000_0103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_valid,
  input  logic              csr_write,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  input  logic              trap_valid,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [XLEN-1:0]   trap_cause,
  input  logic [XLEN-1:0]   trap_tval,
  input  logic              uret_valid,
  input  logic [XLEN-1:1]   irq_lines,
  output logic [XLEN-1:0]   trap_vector,
  output logic [XLEN-1:0]   return_pc,
  output logic              irq_taken
);
  localparam int unsigned VEC_MODE_W = 2;

  csr_sel_e        sel;
  logic            hit, wr_ok, ret_eff;
  logic            gie, sie;
  logic [XLEN-1:0] status_v, ie_v, ip_v, epc_v, cause_v, tval_v, scratch_v, tvec_v;
  logic            unused_pc_lsb;

  assign unused_pc_lsb = trap_pc[0];

  utrap_csr_decode u_dec (
    .addr_i (csr_addr),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  // events win over a software write landing in the same cycle
  assign ret_eff = uret_valid & ~trap_valid;
  assign wr_ok   = csr_valid & csr_write & hit & ~trap_valid & ~uret_valid;

  utrap_status_stack #(.XLEN(XLEN)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_i   (trap_valid),
    .uret_i   (ret_eff),
    .wr_i     (wr_ok && sel == SEL_STATUS),
    .wr_gie_i (csr_wdata[ST_GIE]),
    .wr_sie_i (csr_wdata[ST_SIE]),
    .gie_o    (gie),
    .sie_o    (sie),
    .status_o (status_v)
  );

  utrap_handler_regs #(.XLEN(XLEN), .TVEC_RESET(TVEC_RESET)) u_hregs (
    .clk          (clk),
    .rst_n        (rst_n),
    .trap_i       (trap_valid),
    .uret_i       (ret_eff),
    .trap_pc_i    (trap_pc[XLEN-1:1]),
    .trap_cause_i (trap_cause),
    .trap_tval_i  (trap_tval),
    .wr_epc_i     (wr_ok && sel == SEL_EPC),
    .wr_cause_i   (wr_ok && sel == SEL_CAUSE),
    .wr_tval_i    (wr_ok && sel == SEL_TVAL),
    .wr_scratch_i (wr_ok && sel == SEL_SCRATCH),
    .wr_tvec_i    (wr_ok && sel == SEL_TVEC),
    .wdata_i      (csr_wdata),
    .epc_o        (epc_v),
    .cause_o      (cause_v),
    .tval_o       (tval_v),
    .scratch_o    (scratch_v),
    .tvec_o       (tvec_v)
  );

  utrap_irq_gate #(.XLEN(XLEN)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .gie_i   (gie),
    .wr_ie_i (wr_ok && sel == SEL_IE),
    .wr_ip_i (wr_ok && sel == SEL_IP),
    .wdata_i (csr_wdata),
    .lines_i (irq_lines),
    .ie_o    (ie_v),
    .ip_o    (ip_v),
    .taken_o (irq_taken)
  );

  always_comb begin
    case (sel)
      SEL_STATUS:  csr_rdata = status_v;
      SEL_IE:      csr_rdata = ie_v;
      SEL_TVEC:    csr_rdata = tvec_v;
      SEL_SCRATCH: csr_rdata = scratch_v;
      SEL_EPC:     csr_rdata = epc_v;
      SEL_CAUSE:   csr_rdata = cause_v;
      SEL_TVAL:    csr_rdata = tval_v;
      SEL_IP:      csr_rdata = ip_v;
      default:     csr_rdata = '0;
    endcase
  end

  assign csr_illegal = csr_valid & ~hit;
  assign trap_vector = {tvec_v[XLEN-1:VEC_MODE_W], {VEC_MODE_W{1'b0}}};
  assign return_pc   = epc_v;

  p_illegal_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal |-> (csr_rdata == '0));

  p_trap_drops_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && csr_valid && csr_write && sel == SEL_SCRATCH) |=> $stable(scratch_v));

  p_gate_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> status_v[ST_GIE]);

  p_epc_even_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ok && sel == SEL_EPC) |-> (return_pc[0] == 1'b0));
endmodule

// File: tb/utrap_csr_unit_tb.sv
module utrap_csr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_valid = 0, csr_write = 0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic        csr_illegal;
  logic        trap_valid = 0, uret_valid = 0;
  logic [31:0] trap_pc = '0, trap_cause = '0, trap_tval = '0;
  logic [31:1] irq_lines = '0;
  logic [31:0] trap_vector, return_pc;
  logic        irq_taken;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  utrap_csr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_write(csr_write),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_illegal(csr_illegal), .trap_valid(trap_valid), .trap_pc(trap_pc),
    .trap_cause(trap_cause), .trap_tval(trap_tval), .uret_valid(uret_valid),
    .irq_lines(irq_lines), .trap_vector(trap_vector), .return_pc(return_pc),
    .irq_taken(irq_taken)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_valid = 1; csr_write = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_valid = 0; csr_write = 0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    csr_valid = 1; csr_write = 0; csr_addr = a;
    #1;
    chk(req, csr_rdata, exp);
    csr_valid = 0;
  endtask

  task automatic trap(logic [31:0] pc, logic [31:0] c, logic [31:0] v);
    @(negedge clk);
    trap_valid = 1; trap_pc = pc; trap_cause = c; trap_tval = v;
    @(negedge clk);
    trap_valid = 0;
  endtask

  task automatic uret();
    @(negedge clk);
    uret_valid = 1;
    @(negedge clk);
    uret_valid = 0;
  endtask

  task automatic t_reset();
    rd_chk("R11 status", 12'h000, 0);
    rd_chk("R11 ie", 12'h004, 0);
    rd_chk("R11 tvec", 12'h005, 32'h103);
    rd_chk("R11 scratch", 12'h040, 0);
    rd_chk("R11 epc", 12'h041, 0);
    rd_chk("R11 cause", 12'h042, 0);
    rd_chk("R11 tval", 12'h043, 0);
    rd_chk("R11 ip", 12'h044, 0);
    chk("R11 vector", trap_vector, 32'h100);
    chk("R7 reset taken", {31'd0, irq_taken}, 0);
  endtask

  task automatic t_rw();
    wr(12'h040, 32'hDEAD_BEEF); rd_chk("R1 scratch", 12'h040, 32'hDEAD_BEEF);
    wr(12'h004, 32'h0000_FFFF); rd_chk("R1 ie", 12'h004, 32'h0000_FFFF);
    wr(12'h042, 32'h8000_0007); rd_chk("R1 cause", 12'h042, 32'h8000_0007);
    wr(12'h043, 32'h1234_5678); rd_chk("R1 tval", 12'h043, 32'h1234_5678);
    wr(12'h005, 32'h0000_2001); rd_chk("R1 tvec", 12'h005, 32'h0000_2001);
    chk("R11 vector mask", trap_vector, 32'h0000_2000);
    wr(12'h041, 32'h0000_1235); rd_chk("R12 epc lsb", 12'h041, 32'h0000_1234);
    chk("R12 return_pc", return_pc, 32'h0000_1234);
    wr(12'h000, 32'hFFFF_FFFF); rd_chk("R2 status mask", 12'h000, 32'h11);
    wr(12'h000, 32'h0000_0010); rd_chk("R2 sie only", 12'h000, 32'h10);
    wr(12'h004, 0);
  endtask

  task automatic t_trap();
    wr(12'h000, 32'h1);
    trap(32'h0000_0401, 32'd5, 32'h0000_00AB);
    rd_chk("R3 push", 12'h000, 32'h10);
    rd_chk("R5 epc", 12'h041, 32'h400);
    rd_chk("R5 cause", 12'h042, 5);
    rd_chk("R5 tval", 12'h043, 32'hAB);
    chk("R6 return_pc before", return_pc, 32'h400);
  endtask

  task automatic t_uret();
    uret();
    rd_chk("R4 pop", 12'h000, 32'h11);
    rd_chk("R6 epc", 12'h041, 0);
    rd_chk("R6 cause", 12'h042, 0);
    rd_chk("R6 tval", 12'h043, 0);
    wr(12'h000, 0);
    uret();
    rd_chk("R4 pop zero", 12'h000, 32'h10);
    trap(32'h10, 1, 2);
    rd_chk("R3 push zero", 12'h000, 32'h00);
  endtask

  task automatic t_irq();
    wr(12'h004, 32'h3);
    wr(12'h000, 0);
    wr(12'h044, 32'h1);
    #1 chk("R7 gie off", {31'd0, irq_taken}, 0);
    wr(12'h000, 1);
    #1 chk("R7 sw pend", {31'd0, irq_taken}, 1);
    wr(12'h044, 0);
    #1 chk("R7 none", {31'd0, irq_taken}, 0);
    @(negedge clk); irq_lines = 31'h1;
    #1 chk("R7 line1", {31'd0, irq_taken}, 1);
    rd_chk("R8 ip live", 12'h044, 32'h2);
    @(negedge clk); irq_lines = 31'h2;
    #1 chk("R7 disabled line", {31'd0, irq_taken}, 0);
    @(negedge clk); irq_lines = '0;
    wr(12'h044, 32'hFFFF_FFFE); rd_chk("R8 ro bits", 12'h044, 0);
    wr(12'h004, 0); wr(12'h000, 0);
  endtask

  task automatic t_prio();
    wr(12'h040, 32'h1111);
    wr(12'h000, 32'h1);
    @(negedge clk);
    trap_valid = 1; trap_pc = 32'h800; trap_cause = 9; trap_tval = 3;
    csr_valid = 1; csr_write = 1; csr_addr = 12'h042; csr_wdata = 32'h77;
    @(negedge clk);
    csr_addr = 12'h040; csr_wdata = 32'h55;
    trap_pc = 32'h900;
    @(negedge clk);
    trap_valid = 0; csr_valid = 0; csr_write = 0;
    rd_chk("R9 cause trap wins", 12'h042, 9);
    rd_chk("R9 scratch kept", 12'h040, 32'h1111);
    @(negedge clk);
    uret_valid = 1; csr_valid = 1; csr_write = 1; csr_addr = 12'h041; csr_wdata = 32'h888;
    @(negedge clk);
    uret_valid = 0; csr_valid = 0; csr_write = 0;
    rd_chk("R9 uret wins", 12'h041, 0);
    wr(12'h000, 32'h1);
    @(negedge clk);
    trap_valid = 1; uret_valid = 1; trap_pc = 32'hA00;
    @(negedge clk);
    trap_valid = 0; uret_valid = 0;
    rd_chk("R9 trap over uret", 12'h000, 32'h10);
    rd_chk("R9 trap over uret epc", 12'h041, 32'hA00);
  endtask

  task automatic t_illegal();
    @(negedge clk);
    csr_valid = 1; csr_write = 0; csr_addr = 12'h123;
    #1;
    chk("R10 rdata", csr_rdata, 0);
    chk("R10 flag", {31'd0, csr_illegal}, 1);
    csr_valid = 0;
    @(negedge clk);
    csr_valid = 1; csr_addr = 12'h040;
    #1 chk("R10 flag clear", {31'd0, csr_illegal}, 0);
    csr_valid = 0;
    wr(12'h045, 32'hFFFF_FFFF);
    rd_chk("R10 write ignored scratch", 12'h040, 32'h1111);
    rd_chk("R10 write ignored ip", 12'h044, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rw();
    t_trap();
    t_uret();
    t_irq();
    t_prio();
    t_illegal();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule